// File: doc/BRIEF.md
# Burst-Counting Decimal Totaliser

This block counts the clock-synchronous step pulses that a ramp-type converter emits while it digitises one sample, and keeps the result as packed decimal digits. Each conversion produces one burst of pulses, and the number of pulses in that burst is proportional to the sampled level. Pulses are counted only inside a window. The window opens on the leading edge of the sampling gate and closes a fixed two cycles after the end-of-conversion strobe, so the first and last pulses of a burst are never lost.

In per-burst mode, the count of one burst stays on the outputs until trigger A clears it just before the next burst. In accumulate mode, trigger A is ignored. The counts of a preset number of bursts (1, 10, 100 or 1000) are summed. A decimal down-counter is loaded with that number and steps down on every end-of-conversion strobe. When it reaches zero, the sum freezes and a done flag rises. Only the manual reset releases the freeze. A separate display register captures the count each time a window closes, so the held value survives the clearing done by trigger A.

Top module: `burst_totaliser`

## Requirements
- R1: While rst_n is low, at the next clock edge count_o and disp_o become zero and done_o becomes 0.
- R2: A pulse_i high at a clock edge is counted only inside the window. The window opens at the edge where gate_i is first seen high, and a pulse at that edge counts. The window closes after the edge two cycles past the edge where eoc_i is high, so pulses at edges e, e+1 and e+2 count and a pulse at e+3 does not. A pulse while gate_i has not risen leaves count_o unchanged.
- R3: count_o is packed decimal: digit i sits in bits [4i+3:4i], least significant first. Each digit holds 0 to 9 and carries into the next digit on rolling from 9 to 0.
- R4: With mode_i=0 (per-burst), trig_a_i high at an edge clears count_o to zero. Without it, the count is held between bursts, and done_o stays 0.
- R5: One edge after the window closes, disp_o takes the value of count_o. A later clear of count_o by trig_a_i leaves disp_o unchanged.
- R6: With mode_i=1 (accumulate), trig_a_i has no effect and the counts of successive bursts add up in count_o.
- R7: nsel_i selects the number of bursts: 2'b00 means 1, 2'b01 means 10, 2'b10 means 100 and 2'b11 means 1000. It is sampled at reset and at manual reset. In mode_i=1, each eoc_i steps the burst counter down. done_o rises after the edge that carries the final eoc_i.
- R8: While done_o is 1, count_o does not change and done_o stays 1, until man_rst_i is asserted.
- R9: man_rst_i high at an edge clears count_o and disp_o, drops done_o, and reloads the burst counter from nsel_i.
- R10: When every digit is 9, further pulses leave count_o at all nines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_i | input | 1 | Converter step pulse, one per cycle at most |
| gate_i | input | 1 | Sampling gate; its leading edge opens the window |
| trig_a_i | input | 1 | Trigger A; clears the count in per-burst mode |
| eoc_i | input | 1 | End-of-conversion strobe, one cycle |
| mode_i | input | 1 | 0 = per-burst, 1 = accumulate |
| nsel_i | input | 2 | Burst count select: 00=1, 01=10, 10=100, 11=1000 |
| man_rst_i | input | 1 | Manual reset of count, display and burst counter |
| count_o | output | 4*DIGITS | Live packed-decimal count (DIGITS defaults to 7) |
| disp_o | output | 4*DIGITS | Count captured at the last window close |
| done_o | output | 1 | Preset number of bursts reached; sum frozen |

## Verification
The properties assume the following about the inputs:
- eoc_i is a single-cycle strobe that arrives inside an open window.
- A new gate edge never lands in the two-cycle tail that follows it.
- man_rst_i and trig_a_i are single-cycle events.

Under those conditions, count_o can only stay put, step by one decimal unit, or go to zero. The stimulus always builds bursts as gate rise, pulses, strobe, and then at least four idle cycles. Mode and burst-count changes are made only together with a manual reset. In accumulate mode, no pulse is driven after the final strobe, so the frozen sum is exactly the sum of the pulses driven.

// File: rtl/btot_pkg.sv
// Shared types and helpers for the burst totaliser.
// Assumes packed decimal digits of four bits, least significant digit first.
package btot_pkg;

    localparam int unsigned NIB           = 4;
    localparam int unsigned SCALER_DIGITS = 4;

    typedef logic [NIB-1:0] bcd_t;

    typedef enum logic {
        MODE_ERASE = 1'b0,
        MODE_TOTAL = 1'b1
    } mode_e;

    // Preset for the burst down-counter: a single 1 in decade nsel.
    function automatic logic [NIB*SCALER_DIGITS-1:0] burst_preset(input logic [1:0] sel);
        logic [NIB*SCALER_DIGITS-1:0] v;
        v = '0;
        v[NIB*int'(sel) +: NIB] = 4'd1;
        return v;
    endfunction

endpackage

// File: rtl/btot_bcd_digit.sv
// One decade cell: loads a value, counts up or down modulo ten.
// Assumes up and dn are never high together; load (and reset) wins over both.
// Reset loads ld_val, so the owner decides the reset contents.
module btot_bcd_digit
    import btot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  bcd_t ld_val,
    input  logic up,
    input  logic dn,
    output bcd_t q_o
);

    bcd_t q;

    // Decade register with load, increment and decrement.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            q <= ld_val;
        end else if (up) begin
            q <= (q == 4'd9) ? 4'd0 : q + 4'd1;
        end else if (dn) begin
            q <= (q == 4'd0) ? 4'd9 : q - 4'd1;
        end
    end

    assign q_o = q;

endmodule

// File: rtl/btot_up_chain.sv
// Saturating up-counting chain of decade cells.
// Assumes clr has priority over inc; once every digit reads 9 the chain holds.
module btot_up_chain
    import btot_pkg::*;
#(
    parameter int unsigned DIGITS = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  inc,
    output logic [NIB*DIGITS-1:0] count_o,
    output logic                  full_o
);

    bcd_t              dig [DIGITS];
    logic [DIGITS-1:0] cy;

    // Ripple carry: a digit steps when all digits below it read 9.
    always_comb begin
        full_o = 1'b1;
        for (int i = 0; i < int'(DIGITS); i++) begin
            if (dig[i] != 4'd9) full_o = 1'b0;
        end
        cy[0] = inc && !full_o;
        for (int i = 1; i < int'(DIGITS); i++) begin
            cy[i] = cy[i-1] && (dig[i-1] == 4'd9);
        end
    end

    for (genvar g = 0; g < int'(DIGITS); g++) begin : g_dig
        btot_bcd_digit u_dig (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (clr),
            .ld_val (4'd0),
            .up     (cy[g]),
            .dn     (1'b0),
            .q_o    (dig[g])
        );
        assign count_o[NIB*g +: NIB] = dig[g];
    end

endmodule

// File: rtl/btot_down_scaler.sv
// Decade down-counter that is preset to the burst total and stops at zero.
// Assumes load_val is a legal packed-decimal value; reset also loads it.
module btot_down_scaler
    import btot_pkg::*;
#(
    parameter int unsigned SDIGITS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [NIB*SDIGITS-1:0] load_val,
    input  logic                   dec,
    output logic                   zero_o
);

    bcd_t               dig [SDIGITS];
    logic [SDIGITS-1:0] bw;

    // Ripple borrow: a digit steps down when all digits below it read 0.
    always_comb begin
        zero_o = 1'b1;
        for (int i = 0; i < int'(SDIGITS); i++) begin
            if (dig[i] != 4'd0) zero_o = 1'b0;
        end
        bw[0] = dec && !zero_o;
        for (int i = 1; i < int'(SDIGITS); i++) begin
            bw[i] = bw[i-1] && (dig[i-1] == 4'd0);
        end
    end

    for (genvar g = 0; g < int'(SDIGITS); g++) begin : g_dig
        btot_bcd_digit u_dig (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load),
            .ld_val (load_val[NIB*g +: NIB]),
            .up     (1'b0),
            .dn     (bw[g]),
            .q_o    (dig[g])
        );
    end

endmodule

// File: rtl/btot_window.sv
// Count window: opens on the rising gate edge and closes LAG edges after the
// end-of-conversion strobe.
// Assumes LAG >= 1 and that no new gate edge arrives during the closing tail.
// open_o includes the opening edge itself; closed_o pulses for one cycle
// after the window has shut.
module btot_window #(
    parameter int unsigned LAG = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    input  logic eoc_i,
    output logic open_o,
    output logic closed_o
);

    localparam int unsigned LW = $clog2(LAG + 1);

    logic          gate_q;
    logic          win_q;
    logic          win_d;
    logic [LW-1:0] lag_q;
    logic          rise;

    assign rise = gate_i && !gate_q;

    // Edge detect, window flag and closing-tail counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            win_q  <= 1'b0;
            win_d  <= 1'b0;
            lag_q  <= '0;
        end else begin
            gate_q <= gate_i;
            win_d  <= win_q;
            if (rise) begin
                win_q <= 1'b1;
                lag_q <= '0;
            end else if (eoc_i && win_q) begin
                lag_q <= LW'(LAG);
            end else if (lag_q != '0) begin
                lag_q <= lag_q - LW'(1);
                if (lag_q == LW'(1)) win_q <= 1'b0;
            end
        end
    end

    assign open_o   = win_q || rise;
    assign closed_o = win_d && !win_q;

endmodule

// File: rtl/burst_totaliser.sv
// Burst-counting decimal totaliser. Counts step pulses inside a padded window.
// In per-burst mode trigger A clears the count before each burst; in
// accumulate mode a preset number of bursts is summed and then frozen until
// a manual reset. disp_o keeps the count captured at each window close.
// Assumes eoc_i and man_rst_i are single-cycle strobes; nsel_i is sampled
// at reset and at manual reset only.
module burst_totaliser
    import btot_pkg::*;
#(
    parameter int unsigned DIGITS    = 7,
    parameter int unsigned CLOSE_LAG = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pulse_i,
    input  logic                  gate_i,
    input  logic                  trig_a_i,
    input  logic                  eoc_i,
    input  logic                  mode_i,
    input  logic [1:0]            nsel_i,
    input  logic                  man_rst_i,
    output logic [NIB*DIGITS-1:0] count_o,
    output logic [NIB*DIGITS-1:0] disp_o,
    output logic                  done_o
);

    localparam int unsigned CW = NIB * DIGITS;

    mode_e         mode;
    logic          win_open;
    logic          win_closed;
    logic          frozen;
    logic          cnt_clr;
    logic          cnt_inc;
    logic          full_unused;
    logic [CW-1:0] disp_q;

    assign mode    = mode_e'(mode_i);
    assign cnt_clr = man_rst_i || (mode == MODE_ERASE && trig_a_i && !frozen);
    assign cnt_inc = win_open && pulse_i && !frozen;

    btot_window #(.LAG(CLOSE_LAG)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_i   (gate_i),
        .eoc_i    (eoc_i),
        .open_o   (win_open),
        .closed_o (win_closed)
    );

    btot_up_chain #(.DIGITS(DIGITS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .count_o (count_o),
        .full_o  (full_unused)
    );

    btot_down_scaler #(.SDIGITS(SCALER_DIGITS)) u_scl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (man_rst_i),
        .load_val (burst_preset(nsel_i)),
        .dec      (mode == MODE_TOTAL && eoc_i),
        .zero_o   (frozen)
    );

    // Held display: captures the count once the window has shut.
    always_ff @(posedge clk) begin
        if (!rst_n || man_rst_i) begin
            disp_q <= '0;
        end else if (win_closed) begin
            disp_q <= count_o;
        end
    end

    assign disp_o = disp_q;
    assign done_o = frozen;

endmodule

// File: rtl/btot_checker.sv
// Property checker for burst_totaliser, attached by bind below.
// Assumes single-cycle man_rst_i and a legal packed-decimal count.
module btot_checker #(
    parameter int unsigned DIGITS = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pulse_i,
    input logic                trig_a_i,
    input logic                mode_i,
    input logic                man_rst_i,
    input logic [4*DIGITS-1:0] count_o,
    input logic [4*DIGITS-1:0] disp_o,
    input logic                done_o
);

    function automatic logic [4*DIGITS-1:0] nines();
        logic [4*DIGITS-1:0] v;
        for (int i = 0; i < int'(DIGITS); i++) v[4*i +: 4] = 4'd9;
        return v;
    endfunction

    function automatic logic digits_ok(input logic [4*DIGITS-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < int'(DIGITS); i++) begin
            if (v[4*i +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    localparam logic [4*DIGITS-1:0] ALL9 = nines();

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (count_o == '0 && disp_o == '0 && !done_o));

    a_r3_legal_digits: assert property (@(posedge clk) disable iff (!rst_n)
        digits_ok(count_o) && digits_ok(disp_o));

    a_r2_no_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_i && !trig_a_i && !man_rst_i) |=> $stable(count_o));

    a_r4_trig_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && trig_a_i && !done_o) |=> count_o == '0);

    a_r6_trig_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && trig_a_i && !pulse_i && !man_rst_i) |=> $stable(count_o));

    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !man_rst_i) |=> ($stable(count_o) && done_o));

    a_r9_manual_reset: assert property (@(posedge clk) disable iff (!rst_n)
        man_rst_i |=> (count_o == '0 && disp_o == '0 && !done_o));

    a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == ALL9 && !man_rst_i && !(trig_a_i && !mode_i)) |=> count_o == ALL9);

endmodule

bind burst_totaliser btot_checker #(.DIGITS(DIGITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse_i   (pulse_i),
    .trig_a_i  (trig_a_i),
    .mode_i    (mode_i),
    .man_rst_i (man_rst_i),
    .count_o   (count_o),
    .disp_o    (disp_o),
    .done_o    (done_o)
);

// File: tb/sim_burst_totaliser.sv
module sim_burst_totaliser;

    logic        clk = 1'b0;
    logic        rst_n, pulse, gate, trig, eoc, mode, man_rst;
    logic [1:0]  nsel;
    logic [27:0] count, disp;
    logic [11:0] count3, disp3;
    logic        done, done3;
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    burst_totaliser u0 (
        .clk(clk), .rst_n(rst_n), .pulse_i(pulse), .gate_i(gate), .trig_a_i(trig),
        .eoc_i(eoc), .mode_i(mode), .nsel_i(nsel), .man_rst_i(man_rst),
        .count_o(count), .disp_o(disp), .done_o(done)
    );

    burst_totaliser #(.DIGITS(3)) u1 (
        .clk(clk), .rst_n(rst_n), .pulse_i(pulse), .gate_i(gate), .trig_a_i(trig),
        .eoc_i(eoc), .mode_i(mode), .nsel_i(nsel), .man_rst_i(man_rst),
        .count_o(count3), .disp_o(disp3), .done_o(done3)
    );

    // {trig, pulses[11:0], expected packed-decimal count[27:0]}
    localparam logic [40:0] TBL [8] = '{
        {1'b1, 12'd5,    28'h0000005},
        {1'b1, 12'd9,    28'h0000009},
        {1'b1, 12'd10,   28'h0000010},
        {1'b0, 12'd90,   28'h0000100},
        {1'b1, 12'd199,  28'h0000199},
        {1'b1, 12'd0,    28'h0000000},
        {1'b0, 12'd1000, 28'h0001000},
        {1'b1, 12'd1400, 28'h0001400}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [27:0] act, input logic [27:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic burst(input logic t, input int np);
        if (t) begin trig = 1'b1; tick(); trig = 1'b0; end
        gate = 1'b1; tick();
        for (int k = 0; k < np; k++) begin pulse = 1'b1; tick(); end
        pulse = 1'b0;
        eoc = 1'b1; tick();
        eoc = 1'b0; gate = 1'b0;
        repeat (4) tick();
    endtask

    task automatic manual(input logic m, input logic [1:0] s);
        mode = m; nsel = s; man_rst = 1'b1; tick(); man_rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pulse = 0; gate = 0; trig = 0; eoc = 0; mode = 0; man_rst = 0; nsel = 2'b00;
        repeat (3) tick();
        // R1: reset state
        check("R1 count", count, 28'h0);
        check("R1 disp", disp, 28'h0);
        check("R1 done", {27'h0, done}, 28'h0);
        rst_n = 1'b1; tick();

        // R3 R4 R5: per-burst vectors
        for (int i = 0; i < 8; i++) begin
            burst(TBL[i][40], int'(TBL[i][39:28]));
            check("R3/R4 count", count, TBL[i][27:0]);
            check("R5 disp", disp, TBL[i][27:0]);
            check("R4 done low", {27'h0, done}, 28'h0);
        end

        // R5: trigger clears count but display holds
        trig = 1'b1; tick(); trig = 1'b0;
        check("R4 trig clear", count, 28'h0);
        check("R5 disp held", disp, 28'h0001400);

        // R2: window edges
        gate = 1'b1; pulse = 1'b1; tick();
        eoc = 1'b1; tick();
        eoc = 1'b0; tick();
        tick();
        tick();
        pulse = 1'b0; gate = 1'b0; tick(); tick();
        check("R2 window edges", count, 28'h0000004);
        check("R5 disp after window", disp, 28'h0000004);
        pulse = 1'b1; repeat (5) tick(); pulse = 1'b0;
        check("R2 outside window", count, 28'h0000004);

        // R6 R7 R8: accumulate ten bursts, triggers ignored
        manual(1'b1, 2'b01);
        check("R9 clear count", count, 28'h0);
        check("R9 clear disp", disp, 28'h0);
        for (int b = 1; b <= 10; b++) begin
            burst(1'b1, b);
            if (b == 9) check("R7 not done at 9", {27'h0, done}, 28'h0);
        end
        check("R6 sum of ten", count, 28'h0000055);
        check("R7 done at 10", {27'h0, done}, 28'h1);
        burst(1'b1, 20);
        check("R8 frozen count", count, 28'h0000055);
        check("R8 done held", {27'h0, done}, 28'h1);
        mode = 1'b0; trig = 1'b1; tick(); trig = 1'b0; mode = 1'b1;
        check("R8 trig while frozen", count, 28'h0000055);

        // R9 R7: manual reset, n = 1
        manual(1'b1, 2'b00);
        check("R9 done cleared", {27'h0, done}, 28'h0);
        burst(1'b0, 3);
        check("R7 n=1 done", {27'h0, done}, 28'h1);
        check("R7 n=1 count", count, 28'h0000003);

        // R7: n = 100
        manual(1'b1, 2'b10);
        for (int b = 1; b <= 100; b++) begin
            burst(1'b0, 2);
            if (b == 99) check("R7 not done at 99", {27'h0, done}, 28'h0);
        end
        check("R7 n=100 done", {27'h0, done}, 28'h1);
        check("R7 n=100 count", count, 28'h0000200);

        // R7: n = 1000
        manual(1'b1, 2'b11);
        for (int b = 1; b <= 1000; b++) begin
            burst(1'b0, 1);
            if (b == 999) check("R7 not done at 999", {27'h0, done}, 28'h0);
        end
        check("R7 n=1000 done", {27'h0, done}, 28'h1);
        check("R7 n=1000 count", count, 28'h0001000);

        // R10: saturation on the three-digit instance
        manual(1'b0, 2'b00);
        burst(1'b1, 1005);
        check("R10 saturated", {16'h0, count3}, 28'h0000999);
        check("R10 wide unaffected", count, 28'h0001005);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule